// File: doc/BRIEF.md
# Segmented Range-Fill Flag Array

A linear row of cells, each holding a stop flag and a fill flag, used to build a contiguous enable mask over a row of instruction slots. Writing the mask takes two commands. A mark command records where runs begin and where they end. A fill command then sets the fill flag of every cell from each recorded start rightward, up to and including the first cell whose stop flag is set.

Every run is resolved by one combinational segmented scan, so the fill lands on the clock edge after the command. The run lengths and the number of runs do not change this. The start and stop inputs are sampled only during the mark command. After a fill, the stop flags and pending starts are consumed, so the row is ready for the next mark.

Top module: `segfill_array`

## Requirements
- R1: While the asynchronous active-low reset is held, and after it is released, all fill flags, stop flags and pending starts are zero.
- R2: A mark command (`mark_en` high, `clear` low) ORs `stop_in` into the stop flags and ORs `start_in` into the pending starts. The result is visible on the next clock edge, and the fill flags do not change.
- R3: A fill command (`fill_en` high with `mark_en` and `clear` low) sets fill flag i on the next edge when some pending start j ≤ i exists and no stop flag is set at any k with j ≤ k < i.
- R4: A pending start at a cell whose own stop flag is set fills only that cell.
- R5: A pending start with no stop flag at or to its right fills through to cell N-1.
- R6: A fill only adds fill flags. Flags already set stay set, and only clear or reset lowers them.
- R7: On the edge that completes a fill, all stop flags and pending starts become zero. A second fill with no mark in between leaves the fill flags unchanged.
- R8: When `mark_en` is low, `start_in` and `stop_in` have no effect on any flag.
- R9: `clear` zeroes every flag on the next edge and takes priority over mark and fill.
- R10: When mark and fill are requested in the same cycle, the mark is applied and the fill is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of all flags |
| mark_en | input | 1 | Mark command strobe |
| fill_en | input | 1 | Fill command strobe |
| start_in | input | N | Run start positions, one bit per cell |
| stop_in | input | N | Run stop positions, one bit per cell |
| fill_flags | output | N | Registered fill flags |
| stop_flags | output | N | Registered stop flags |

## Verification
The assertions assume the strobes are driven to known levels in every cycle after reset. They also assume the bus values seen in a cycle are the values present at that clock edge. The bench changes the strobes and vectors only on the falling clock edge, so each rising edge sees one settled command. Start and stop vectors with the wrong polarity, such as a start to the right of a stop, and strobe collisions are applied on purpose. This way the priority and masking rules are exercised rather than avoided.

// File: rtl/segfill_pkg.sv
package segfill_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_MARK  = 2'd2,
        OP_FILL  = 2'd3
    } segfill_op_e;
endpackage

// File: rtl/segfill_decode.sv
module segfill_decode
    import segfill_pkg::*;
(
    input  logic        clear,
    input  logic        mark_en,
    input  logic        fill_en,
    output segfill_op_e op
);
    // Priority: clear, then mark, then fill.
    always_comb begin
        if (clear)        op = OP_CLEAR;
        else if (mark_en) op = OP_MARK;
        else if (fill_en) op = OP_FILL;
        else              op = OP_IDLE;
    end
endmodule

// File: rtl/segfill_scan.sv
module segfill_scan #(
    parameter int N = 16
) (
    input  logic [N-1:0] starts,
    input  logic [N-1:0] stops,
    output logic [N-1:0] reach
);
    // Segmented prefix: a run enters at a start and is cut after a stop cell.
    always_comb begin
        logic carry;
        carry = 1'b0;
        for (int i = 0; i < N; i++) begin
            reach[i] = starts[i] | carry;
            carry    = reach[i] & ~stops[i];
        end
    end
endmodule

// File: rtl/segfill_array.sv
module segfill_array
    import segfill_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         mark_en,
    input  logic         fill_en,
    input  logic [N-1:0] start_in,
    input  logic [N-1:0] stop_in,
    output logic [N-1:0] fill_flags,
    output logic [N-1:0] stop_flags
);
    typedef struct packed {
        logic [N-1:0] fill;
        logic [N-1:0] stop;
        logic [N-1:0] start;
    } cells_t;

    cells_t      cells_d, cells_q;
    segfill_op_e op;
    logic [N-1:0] reach;

    segfill_decode u_decode (
        .clear  (clear),
        .mark_en(mark_en),
        .fill_en(fill_en),
        .op     (op)
    );

    segfill_scan #(.N(N)) u_scan (
        .starts(cells_q.start),
        .stops (cells_q.stop),
        .reach (reach)
    );

    always_comb begin
        cells_d = cells_q;
        unique case (op)
            OP_CLEAR: cells_d = '0;
            OP_MARK: begin
                cells_d.stop  = cells_q.stop | stop_in;
                cells_d.start = cells_q.start | start_in;
            end
            OP_FILL: begin
                cells_d.fill  = cells_q.fill | reach;
                cells_d.stop  = '0;
                cells_d.start = '0;
            end
            default: cells_d = cells_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cells_q <= '0;
        else        cells_q <= cells_d;
    end

    assign fill_flags = cells_q.fill;
    assign stop_flags = cells_q.stop;
endmodule

// File: rtl/segfill_array_chk.sv
module segfill_array_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clear,
    input logic         mark_en,
    input logic         fill_en,
    input logic [N-1:0] stop_in,
    input logic [N-1:0] fill_flags,
    input logic [N-1:0] stop_flags
);
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill_flags == '0 && stop_flags == '0));

    assert_mark_sets_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_en && !clear) |=> ((stop_flags & $past(stop_in)) == $past(stop_in)
                                 && $stable(fill_flags)));

    assert_fill_consumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !mark_en && !clear) |=> (stop_flags == '0));

    assert_fill_accumulates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((fill_flags & $past(fill_flags)) == $past(fill_flags)));

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !mark_en && !fill_en) |=> ($stable(stop_flags) && $stable(fill_flags)));
endmodule

bind segfill_array segfill_array_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .mark_en   (mark_en),
    .fill_en   (fill_en),
    .stop_in   (stop_in),
    .fill_flags(fill_flags),
    .stop_flags(stop_flags)
);

// File: tb/segfill_array_bench.sv
`timescale 1ns/1ps
module segfill_array_bench;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear = 1'b0, mark_en = 1'b0, fill_en = 1'b0;
    logic [N-1:0] start_in = '0, stop_in = '0;
    logic [N-1:0] fill_flags, stop_flags;

    int tests = 0, fails = 0;
    string req = "R1";

    // behavioural reference state
    bit m_fill[N], m_stop[N], m_start[N];

    always #5 clk = ~clk;

    segfill_array #(.N(N)) u_segfill_array (
        .clk(clk), .rst_n(rst_n), .clear(clear), .mark_en(mark_en),
        .fill_en(fill_en), .start_in(start_in), .stop_in(stop_in),
        .fill_flags(fill_flags), .stop_flags(stop_flags)
    );

    function automatic logic [N-1:0] pack(bit a[N]);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = a[i];
        return v;
    endfunction

    task automatic model_edge();
        if (!rst_n || clear) begin
            for (int i = 0; i < N; i++) begin m_fill[i] = 0; m_stop[i] = 0; m_start[i] = 0; end
        end else if (mark_en) begin
            for (int i = 0; i < N; i++) begin
                if (stop_in[i])  m_stop[i] = 1;
                if (start_in[i]) m_start[i] = 1;
            end
        end else if (fill_en) begin
            for (int j = 0; j < N; j++) begin
                if (m_start[j]) begin
                    int k = j;
                    while (k < N) begin
                        m_fill[k] = 1;
                        if (m_stop[k]) break;
                        k++;
                    end
                end
            end
            for (int i = 0; i < N; i++) begin m_stop[i] = 0; m_start[i] = 0; end
        end
    endtask

    task automatic compare();
        tests++;
        if (fill_flags !== pack(m_fill)) begin
            fails++;
            $display("FAIL %s fill_flags actual=%h expected=%h", req, fill_flags, pack(m_fill));
        end
        tests++;
        if (stop_flags !== pack(m_stop)) begin
            fails++;
            $display("FAIL %s stop_flags actual=%h expected=%h", req, stop_flags, pack(m_stop));
        end
    endtask

    // one clock: inputs already set at the falling edge
    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic drive(input logic c, input logic m, input logic f,
                         input logic [N-1:0] s, input logic [N-1:0] p);
        clear = c; mark_en = m; fill_en = f; start_in = s; stop_in = p;
        cycle();
        clear = 0; mark_en = 0; fill_en = 0; start_in = '0; stop_in = '0;
    endtask

    initial begin
        int wd = 0;
        while (wd < 20000) begin @(posedge clk); wd++; end
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        req = "R1";
        @(negedge clk); model_edge(); compare();
        @(negedge clk); rst_n = 1'b1;
        cycle();

        // R2 then R3: one run from cell 2 to cell 5
        req = "R2"; drive(0, 1, 0, 16'h0004, 16'h0020);
        req = "R3"; drive(0, 0, 1, '0, '0);
        // R7: second fill with no mark changes nothing
        req = "R7"; drive(0, 0, 1, '0, '0);

        // R3/R6: two runs at once over existing flags (0..3, 8..10)
        req = "R6"; drive(0, 1, 0, 16'h0101, 16'h0408);
        req = "R6"; drive(0, 0, 1, '0, '0);

        // R9: clear beats a simultaneous mark and fill
        req = "R9"; drive(1, 1, 1, 16'hFFFF, 16'hFFFF);

        // R4: start on its own stop cell fills only that cell
        req = "R4"; drive(0, 1, 0, 16'h1000, 16'h1000);
        req = "R4"; drive(0, 0, 1, '0, '0);

        // R5: start with stop to its left runs to the top cell
        req = "R5"; drive(0, 1, 0, 16'h0040, 16'h0010);
        req = "R5"; drive(0, 0, 1, '0, '0);

        // R8: vectors ignored while mark is low
        req = "R8"; drive(0, 0, 0, 16'hFFFF, 16'hFFFF);
        req = "R8"; drive(0, 0, 1, 16'h0001, 16'h0000);

        // R10: mark and fill together apply only the mark
        req = "R9"; drive(1, 0, 0, '0, '0);
        req = "R10"; drive(0, 1, 1, 16'h0002, 16'h0008);
        req = "R10"; drive(0, 0, 1, '0, '0);

        // R2: marks accumulate across two commands
        req = "R2"; drive(0, 1, 0, 16'h0100, 16'h0200);
        req = "R2"; drive(0, 1, 0, 16'h2000, 16'h4000);
        req = "R3"; drive(0, 0, 1, '0, '0);

        // R1: asynchronous reset mid-operation
        req = "R1"; drive(0, 1, 0, 16'h0001, 16'h8000);
        rst_n = 1'b0; #1;
        for (int i = 0; i < N; i++) begin m_fill[i] = 0; m_stop[i] = 0; m_start[i] = 0; end
        compare();
        @(negedge clk); rst_n = 1'b1;
        req = "R7"; drive(0, 0, 1, '0, '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule